// File: doc/BRIEF.md
# Output Color Matrix with Legal-Range Clamp

This block sits on the pixel path between a compositor and its display output FIFOs. It takes a 24-bit RGB pixel stream in which every pixel carries a tag naming the output FIFO it is headed for. Pixels tagged for the one FIFO that software selects pass through a programmable 3x3 color matrix. Each of the nine weights is a signed fraction. The matrix result is rounded, a signed per-channel offset is added, and the result is limited to either the full 8-bit range or the video-legal range.

Pixels bound for any other FIFO leave the block bit-exact. When the selector is zero, the matrix is off for every FIFO. All pixels see the same three-cycle latency, and the valid flag and FIFO tag travel with the data. The configuration inputs are meant to be held steady while pixels are in flight; they are not captured per pixel.

Top module: `pix_color_matrix`

## Requirements
- R1: A pixel presented with `in_valid` high appears on the outputs exactly 3 clock cycles later, with `out_valid` high and `out_fifo` equal to its `in_fifo`. A cycle with `in_valid` low yields `out_valid` low 3 cycles later.
- R2: The FIFO selector is encoded as follows: `cfg_sel` 1, 2 and 3 select FIFO tags 0, 1 and 2. A pixel whose `in_fifo` tag is not the selected one leaves with `out_rgb` equal to its `in_rgb`, unchanged.
- R3: When `cfg_sel` is 0, every pixel passes through unchanged, whatever its tag.
- R4: Pixels are packed with R in bits 23:16, G in 15:8 and B in 7:0. Each of `cfg_coef_r`, `cfg_coef_g` and `cfg_coef_b` holds the weights from that input channel to output R (bits 29:20), G (19:10) and B (9:0). Each weight is a 10-bit two's complement value scaled by 1/512. For a selected pixel, each output channel is computed from the sum of the three unsigned input components multiplied by their weights toward that output.
- R5: The weighted sum is kept at full precision, 256 is added, and the sum is shifted right arithmetically by 9 bits. This is round-to-nearest with ties toward plus infinity.
- R6: `cfg_offs` holds 8-bit two's complement offsets, R in bits 23:16, G in 15:8 and B in 7:0. Each offset is added to its rounded channel result before limiting.
- R7: When `cfg_clamp` is 0, each channel is saturated to 0..255.
- R8: When `cfg_clamp` is 1, R is limited to 16..235 and G and B are limited to 16..240.
- R9: While `rst_n` is low, `out_valid` is 0 and `out_rgb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_fifo | input | 2 | Destination FIFO tag of the input pixel (0..2) |
| in_rgb | input | 24 | Input pixel, R 23:16, G 15:8, B 7:0 |
| cfg_sel | input | 2 | FIFO selector: 0 off, 1..3 select tag 0..2 |
| cfg_clamp | input | 1 | 1 selects the video-legal limits |
| cfg_coef_r | input | 30 | Weights from input R to output R/G/B |
| cfg_coef_g | input | 30 | Weights from input G to output R/G/B |
| cfg_coef_b | input | 30 | Weights from input B to output R/G/B |
| cfg_offs | input | 24 | Signed offsets for R/G/B |
| out_valid | output | 1 | Output pixel valid |
| out_fifo | output | 2 | Destination FIFO tag of the output pixel |
| out_rgb | output | 24 | Output pixel |

## Verification
The hardest cases to reach are the exact boundaries of rounding and limiting. These are a weighted sum that lands on or near a half LSB, and a result that sits one step inside or outside 16, 235, 240 or 255 after a negative offset. Random weights almost never hit them. Directed configurations use tiny weights of 1/512 and 2/512, near-unity and negative diagonals, and extreme offsets to land on those edges in both limit modes. Seeded random rounds then mix FIFO tags, selectors and valid gaps, draining the pipeline before each configuration change.

// File: rtl/pcm_pkg.sv
`timescale 1ns/1ps
package pcm_pkg;
  localparam int PIX_W  = 8;
  localparam int COEF_W = 10;
  localparam int FRAC_W = 9;
  localparam int OFFS_W = 8;
  localparam int NCH    = 3;
  localparam int TAG_W  = 2;
  localparam int PROD_W = PIX_W + 1 + COEF_W;
  localparam int SUM_W  = PROD_W + 2;
  localparam int ACC_W  = SUM_W - FRAC_W + 1;

  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [SUM_W-1:0]  sum_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  // unsigned pixel times signed weight
  function automatic prod_t mul_px(input logic [PIX_W-1:0] px,
                                   input logic signed [COEF_W-1:0] k);
    logic signed [PIX_W:0] pxs;
    pxs = $signed({1'b0, px});
    return pxs * k;
  endfunction

  // add half LSB, drop fraction, add signed offset
  function automatic acc_t round_offs(input sum_t s,
                                      input logic signed [OFFS_W-1:0] o);
    sum_t r;
    acc_t sh;
    r  = s + sum_t'(1 <<< (FRAC_W-1));
    sh = acc_t'(r >>> FRAC_W);
    return sh + acc_t'(o);
  endfunction

  // limit a signed value into [lo, hi]
  function automatic logic [PIX_W-1:0] limit(input acc_t a, input acc_t lo,
                                             input acc_t hi);
    if (a < lo)      return lo[PIX_W-1:0];
    else if (a > hi) return hi[PIX_W-1:0];
    else             return a[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/pcm_chan.sv
`timescale 1ns/1ps
module pcm_chan
  import pcm_pkg::*;
#(
  parameter int HI_LEGAL = 235,
  parameter int LO_LEGAL = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PIX_W-1:0]         px_r,
  input  logic [PIX_W-1:0]         px_g,
  input  logic [PIX_W-1:0]         px_b,
  input  logic signed [COEF_W-1:0] k_r,
  input  logic signed [COEF_W-1:0] k_g,
  input  logic signed [COEF_W-1:0] k_b,
  input  logic signed [OFFS_W-1:0] offs,
  input  logic                     clamp,
  output logic [PIX_W-1:0]         y
);
  localparam acc_t LO_L = acc_t'(LO_LEGAL);
  localparam acc_t HI_L = acc_t'(HI_LEGAL);
  localparam acc_t HI_F = acc_t'((1 << PIX_W) - 1);

  prod_t p_r_q, p_g_q, p_b_q;
  acc_t  acc_q;
  logic [PIX_W-1:0] y_q;

  sum_t sum_w;
  acc_t acc_w, lo_w, hi_w;
  logic over_hi_w, under_lo_w;

  assign sum_w      = sum_t'(p_r_q) + sum_t'(p_g_q) + sum_t'(p_b_q);
  assign acc_w      = round_offs(sum_w, offs);
  assign lo_w       = clamp ? LO_L : '0;
  assign hi_w       = clamp ? HI_L : HI_F;
  assign over_hi_w  = acc_q > hi_w;
  assign under_lo_w = acc_q < lo_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_r_q <= '0;
      p_g_q <= '0;
      p_b_q <= '0;
      acc_q <= '0;
      y_q   <= '0;
    end else begin
      p_r_q <= mul_px(px_r, k_r);
      p_g_q <= mul_px(px_g, k_g);
      p_b_q <= mul_px(px_b, k_b);
      acc_q <= acc_w;
      y_q   <= limit(acc_q, lo_w, hi_w);
    end
  end

  assign y = y_q;

  AST_LEGAL_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp && over_hi_w) |=> (y_q == HI_L[PIX_W-1:0])); // R8
  AST_LEGAL_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp && under_lo_w) |=> (y_q == LO_L[PIX_W-1:0])); // R8
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clamp && over_hi_w) |=> (y_q == HI_F[PIX_W-1:0])); // R7
  AST_SAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!clamp && under_lo_w) |=> (y_q == '0)); // R7
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!over_hi_w && !under_lo_w) |=> (y_q == $past(acc_q[PIX_W-1:0]))); // R6
endmodule

// File: rtl/pcm_tag_pipe.sv
`timescale 1ns/1ps
module pcm_tag_pipe
  import pcm_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [TAG_W-1:0]       in_fifo,
  input  logic                   in_apply,
  input  logic [NCH*PIX_W-1:0]   in_rgb,
  output logic                   out_valid,
  output logic [TAG_W-1:0]       out_fifo,
  output logic                   out_apply,
  output logic [NCH*PIX_W-1:0]   out_rgb
);
  logic                 v_q   [DEPTH];
  logic [TAG_W-1:0]     f_q   [DEPTH];
  logic                 a_q   [DEPTH];
  logic [NCH*PIX_W-1:0] rgb_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic                 v_d, a_d;
    logic [TAG_W-1:0]     f_d;
    logic [NCH*PIX_W-1:0] rgb_d;
    if (s == 0) begin : g_head
      assign v_d   = in_valid;
      assign f_d   = in_fifo;
      assign a_d   = in_apply;
      assign rgb_d = in_rgb;
    end else begin : g_body
      assign v_d   = v_q[s-1];
      assign f_d   = f_q[s-1];
      assign a_d   = a_q[s-1];
      assign rgb_d = rgb_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[s]   <= 1'b0;
        f_q[s]   <= '0;
        a_q[s]   <= 1'b0;
        rgb_q[s] <= '0;
      end else begin
        v_q[s]   <= v_d;
        f_q[s]   <= f_d;
        a_q[s]   <= a_d;
        rgb_q[s] <= rgb_d;
      end
    end
  end

  assign out_valid = v_q[DEPTH-1];
  assign out_fifo  = f_q[DEPTH-1];
  assign out_apply = a_q[DEPTH-1];
  assign out_rgb   = rgb_q[DEPTH-1];
endmodule

// File: rtl/pix_color_matrix.sv
`timescale 1ns/1ps
module pix_color_matrix
  import pcm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [TAG_W-1:0]        in_fifo,
  input  logic [NCH*PIX_W-1:0]    in_rgb,
  input  logic [TAG_W-1:0]        cfg_sel,
  input  logic                    cfg_clamp,
  input  logic [NCH*COEF_W-1:0]   cfg_coef_r,
  input  logic [NCH*COEF_W-1:0]   cfg_coef_g,
  input  logic [NCH*COEF_W-1:0]   cfg_coef_b,
  input  logic [NCH*OFFS_W-1:0]   cfg_offs,
  output logic                    out_valid,
  output logic [TAG_W-1:0]        out_fifo,
  output logic [NCH*PIX_W-1:0]    out_rgb
);
  localparam int LAT = 3;

  logic                 hit_w;
  logic                 tag_apply;
  logic [NCH*PIX_W-1:0] tag_rgb;
  logic [NCH*PIX_W-1:0] mat_rgb;

  assign hit_w = (cfg_sel != '0) && ((cfg_sel - TAG_W'(1)) == in_fifo);

  pcm_tag_pipe #(.DEPTH(LAT)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_fifo  (in_fifo),
    .in_apply (hit_w),
    .in_rgb   (in_rgb),
    .out_valid(out_valid),
    .out_fifo (out_fifo),
    .out_apply(tag_apply),
    .out_rgb  (tag_rgb)
  );

  // channel c: 0 = R, 1 = G, 2 = B; packed MSB first
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int FLD = NCH - 1 - c;
    logic [PIX_W-1:0] y_c;
    pcm_chan #(
      .HI_LEGAL(c == 0 ? 235 : 240),
      .LO_LEGAL(16)
    ) u_ch (
      .clk  (clk),
      .rst_n(rst_n),
      .px_r (in_rgb[2*PIX_W +: PIX_W]),
      .px_g (in_rgb[PIX_W +: PIX_W]),
      .px_b (in_rgb[0 +: PIX_W]),
      .k_r  ($signed(cfg_coef_r[FLD*COEF_W +: COEF_W])),
      .k_g  ($signed(cfg_coef_g[FLD*COEF_W +: COEF_W])),
      .k_b  ($signed(cfg_coef_b[FLD*COEF_W +: COEF_W])),
      .offs ($signed(cfg_offs[FLD*OFFS_W +: OFFS_W])),
      .clamp(cfg_clamp),
      .y    (y_c)
    );
    assign mat_rgb[FLD*PIX_W +: PIX_W] = y_c;
  end

  assign out_rgb = tag_apply ? mat_rgb : tag_rgb;

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##2 out_valid); // R1
  AST_IDLE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##2 !out_valid); // R1
  AST_TAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##2 (out_fifo == $past(in_fifo, 3))); // R1
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !hit_w) |=> ##2 (out_rgb == $past(in_rgb, 3))); // R2
  AST_SEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_sel == '0) |=> ##2 (out_rgb == $past(in_rgb, 3))); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_rgb == '0)); // R9
endmodule

// File: tb/pix_color_matrix_tb.sv
`timescale 1ns/1ps
module pix_color_matrix_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_fifo;
  logic [23:0] in_rgb;
  logic [1:0]  cfg_sel;
  logic        cfg_clamp;
  logic [29:0] cfg_coef_r, cfg_coef_g, cfg_coef_b;
  logic [23:0] cfg_offs;
  logic        out_valid;
  logic [1:0]  out_fifo;
  logic [23:0] out_rgb;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pix_color_matrix u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fifo(in_fifo),
    .in_rgb(in_rgb), .cfg_sel(cfg_sel), .cfg_clamp(cfg_clamp),
    .cfg_coef_r(cfg_coef_r), .cfg_coef_g(cfg_coef_g), .cfg_coef_b(cfg_coef_b),
    .cfg_offs(cfg_offs), .out_valid(out_valid), .out_fifo(out_fifo),
    .out_rgb(out_rgb)
  );

  // expected-value slots, slot 2 is due at the current negedge
  logic        e_v   [3];
  logic [1:0]  e_f   [3];
  logic [23:0] e_rgb [3];
  string       e_tag [3];

  function automatic int sx(input int v, input int bits);
    return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
  endfunction

  function automatic logic [23:0] model(input logic [23:0] rgb, input logic [1:0] fid);
    logic [23:0] res;
    int comp [3];
    if (cfg_sel == 2'd0 || int'(cfg_sel) - 1 != int'(fid)) return rgb;
    for (int i = 0; i < 3; i++) comp[i] = int'(rgb[23 - 8*i -: 8]);
    for (int c = 0; c < 3; c++) begin
      int sum, t, q, v, lo, hi;
      sum = 0;
      for (int i = 0; i < 3; i++) begin
        logic [29:0] grp;
        grp = (i == 0) ? cfg_coef_r : (i == 1) ? cfg_coef_g : cfg_coef_b;
        sum += comp[i] * sx(int'(grp[29 - 10*c -: 10]), 10);
      end
      t = sum + 256;
      q = (t >= 0) ? t / 512 : -((-t + 511) / 512);
      v = q + sx(int'(cfg_offs[23 - 8*c -: 8]), 8);
      lo = cfg_clamp ? 16 : 0;
      hi = cfg_clamp ? ((c == 0) ? 235 : 240) : 255;
      if (v < lo) v = lo;
      if (v > hi) v = hi;
      res[23 - 8*c -: 8] = 8'(v);
    end
    return res;
  endfunction

  task automatic step(input logic v, input logic [1:0] fid, input logic [23:0] rgb,
                      input string tag);
    @(negedge clk);
    checks++;
    if (out_valid !== e_v[2]) begin
      errors++;
      $display("FAIL R1 (%s) valid: got %b expected %b", e_tag[2], out_valid, e_v[2]);
    end
    if (e_v[2]) begin
      checks++;
      if (out_fifo !== e_f[2]) begin
        errors++;
        $display("FAIL R1 (%s) fifo tag: got %0d expected %0d", e_tag[2], out_fifo, e_f[2]);
      end
      checks++;
      if (out_rgb !== e_rgb[2]) begin
        errors++;
        $display("FAIL %s pixel: got %h expected %h", e_tag[2], out_rgb, e_rgb[2]);
      end
    end
    for (int s = 2; s > 0; s--) begin
      e_v[s] = e_v[s-1]; e_f[s] = e_f[s-1]; e_rgb[s] = e_rgb[s-1]; e_tag[s] = e_tag[s-1];
    end
    e_v[0] = v; e_f[0] = fid; e_rgb[0] = model(rgb, fid); e_tag[0] = tag;
    in_valid = v; in_fifo = fid; in_rgb = rgb;
  endtask

  task automatic set_cfg(input logic [1:0] sel, input logic clamp, input logic [29:0] kr,
                         input logic [29:0] kg, input logic [29:0] kb, input logic [23:0] of);
    for (int i = 0; i < 3; i++) step(1'b0, 2'd0, 24'h0, "R1");
    cfg_sel = sel; cfg_clamp = clamp;
    cfg_coef_r = kr; cfg_coef_g = kg; cfg_coef_b = kb; cfg_offs = of;
  endtask

  localparam logic [29:0] DIAG_R = {10'h1FF, 10'h000, 10'h000};
  localparam logic [29:0] DIAG_G = {10'h000, 10'h1FF, 10'h000};
  localparam logic [29:0] DIAG_B = {10'h000, 10'h000, 10'h1FF};
  localparam logic [29:0] ALL_HI = {10'h1FF, 10'h1FF, 10'h1FF};
  localparam logic [29:0] ALL_NG = {10'h200, 10'h200, 10'h200};

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    for (int s = 0; s < 3; s++) begin
      e_v[s] = 1'b0; e_f[s] = '0; e_rgb[s] = '0; e_tag[s] = "R9";
    end
    rst_n = 1'b0; in_valid = 1'b0; in_fifo = '0; in_rgb = '0;
    cfg_sel = '0; cfg_clamp = 1'b0;
    cfg_coef_r = '0; cfg_coef_g = '0; cfg_coef_b = '0; cfg_offs = '0;
    repeat (3) @(negedge clk);
    in_valid = 1'b1; in_rgb = 24'hABCDEF;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_rgb !== 24'h0) begin
      errors++;
      $display("FAIL R9 reset: got v=%b rgb=%h expected v=0 rgb=000000", out_valid, out_rgb);
    end
    in_valid = 1'b0; in_rgb = '0;
    @(negedge clk);
    rst_n = 1'b1;

    // near-unity diagonal on FIFO 0, other tags pass through
    set_cfg(2'd1, 1'b0, DIAG_R, DIAG_G, DIAG_B, 24'h0);
    step(1'b1, 2'd0, 24'hFF8001, "R4");
    step(1'b1, 2'd0, 24'h123456, "R4");
    step(1'b1, 2'd1, 24'h123456, "R2");
    step(1'b1, 2'd2, 24'hFEDCBA, "R2");
    step(1'b0, 2'd0, 24'h777777, "R1");
    step(1'b1, 2'd0, 24'h000000, "R4");

    // matrix off for all tags
    set_cfg(2'd0, 1'b1, ALL_NG, ALL_NG, ALL_NG, 24'h7F7F7F);
    for (int f = 0; f < 3; f++) step(1'b1, 2'(f), 24'h010203 * (f + 1), "R3");

    // rounding: weights of 1, 2, -1, -2 on R only, FIFO 2
    set_cfg(2'd3, 1'b0, {10'd1, 10'd2, 10'h3FF}, 30'h0, 30'h0, 24'h00000A);
    step(1'b1, 2'd2, 24'hFF0000, "R5");
    step(1'b1, 2'd2, 24'h800000, "R5");
    step(1'b1, 2'd2, 24'h010000, "R5");
    set_cfg(2'd3, 1'b0, {10'h3FE, 10'h3FE, 10'h3FE}, 30'h0, 30'h0, 24'h0A0A0A);
    step(1'b1, 2'd2, 24'hFF0000, "R5");
    step(1'b1, 2'd2, 24'h810000, "R5");

    // offsets, both signs
    set_cfg(2'd2, 1'b0, DIAG_R, DIAG_G, DIAG_B, {8'h80, 8'h7F, 8'hF0});
    step(1'b1, 2'd1, 24'hFF0040, "R6");
    step(1'b1, 2'd1, 24'h808080, "R6");
    step(1'b1, 2'd1, 24'h00FF10, "R6");

    // full-range saturation
    set_cfg(2'd1, 1'b0, ALL_HI, ALL_HI, ALL_HI, 24'h0);
    step(1'b1, 2'd0, 24'hFFFFFF, "R7");
    set_cfg(2'd1, 1'b0, ALL_NG, ALL_NG, ALL_NG, 24'h0);
    step(1'b1, 2'd0, 24'h102030, "R7");

    // legal-range limits and edges
    set_cfg(2'd1, 1'b1, ALL_HI, ALL_HI, ALL_HI, 24'h0);
    step(1'b1, 2'd0, 24'hFFFFFF, "R8");
    set_cfg(2'd1, 1'b1, ALL_NG, ALL_NG, ALL_NG, 24'h0);
    step(1'b1, 2'd0, 24'h405060, "R8");
    set_cfg(2'd1, 1'b1, DIAG_R, DIAG_G, DIAG_B, 24'h0);
    step(1'b1, 2'd0, 24'hEBF0F0, "R8");
    step(1'b1, 2'd0, 24'hECF1F1, "R8");
    step(1'b1, 2'd0, 24'h101010, "R8");
    step(1'b1, 2'd0, 24'h0F0F0F, "R8");

    // seeded random rounds
    for (int r = 0; r < 24; r++) begin
      set_cfg(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
              30'($urandom), 30'($urandom), 30'($urandom), 24'($urandom));
      for (int n = 0; n < 250; n++)
        step(1'($urandom_range(0, 9) < 7), 2'($urandom_range(0, 2)), 24'($urandom),
             (r % 2 == 0) ? "R4" : "R1");
    end
    for (int i = 0; i < 3; i++) step(1'b0, 2'd0, 24'h0, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule